// File: doc/BRIEF.md
# Square Tone Channel with Frequency Sweep

This block is a single audio voice that produces a square wave from a fixed system clock. An 11-bit frequency code sets the wave period: each wave cycle has 32 phase steps, and each step lasts (2048 − code) clocks. A 2-bit code picks how much of the cycle is high. While the wave is high, the output carries a 4-bit volume level. A slow envelope raises or lowers that level in single steps.

Three slow strobes drive the timed features. The 128 Hz strobe drives a sweep that moves the working frequency up or down by a shifted copy of itself. The 64 Hz strobe paces the envelope. The 256 Hz strobe counts down an optional play length. A trigger strobe restarts the voice: it reloads the frequency, the envelope and the length, and sets the active flag. The flag clears when the length runs out or when an upward sweep passes the top of the frequency range. The surrounding sound system reads the flag as status and mixes the amplitude sample with other voices.

Top module: `sqtone_chan`

## Requirements
- R1: After reset, `active` is 0 and `sample` is 0.
- R2: A one-cycle pulse on `trig` sets `active` at the next clock edge. The envelope level is reloaded from `env_init` and the wave restarts at phase step 0 (the start of the high part), using the period from `freq`. A trigger also restarts a channel that has stopped.
- R3: Each phase step lasts (2048 − `freq`) clocks, and one wave cycle is 32 phase steps.
- R4: The `duty` code sets how many of the 32 steps at the start of each cycle are high: 0 gives 4 steps, 1 gives 8, 2 gives 16 and 3 gives 24.
- R5: `sample` equals the current envelope level while the channel is active and the phase is high. In every other case it is 0.
- R6: When `env_step` = E is nonzero, the level moves by one every E pulses of `tick64`. It goes up when `env_up` = 1 and down when `env_up` = 0. The level stops at 0 and at 15 and never wraps. When E = 0 the level is frozen.
- R7: When `sweep_time` = k is nonzero, a sweep event happens every k pulses of `tick128`, counted from the trigger. When `sweep_time` = 0 there are no sweep events.
- R8: A sweep event replaces the working frequency F with F + (F >> n) when `sweep_sub` = 0, or with F − (F >> n) when `sweep_sub` = 1, where n = `sweep_shift`. A subtraction whose result would be negative leaves F unchanged. The new period takes effect at the next phase step.
- R9: If an addition sweep would give a value of 2048 or more, the frequency is left unchanged and `active` clears at that same edge.
- R10: With `timed` = 1, `active` clears on the (64 − `len_val`)-th pulse of `tick256` after the trigger. With `timed` = 0, `len_val` and `tick256` have no effect.
- R11: When the `freq` input changes without a trigger, the new value becomes the working frequency and sets the period from the next phase step on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sweep_shift | input | 3 | Sweep shift count n |
| sweep_sub | input | 1 | Sweep direction: 0 adds, 1 subtracts |
| sweep_time | input | 3 | Sweep interval in 128 Hz pulses; 0 turns the sweep off |
| duty | input | 2 | High-fraction code |
| env_step | input | 3 | Envelope interval in 64 Hz pulses; 0 freezes the level |
| env_up | input | 1 | Envelope direction: 1 raises, 0 lowers |
| env_init | input | 4 | Level loaded on trigger |
| len_val | input | 6 | Length code L; play time is (64 − L) pulses of 256 Hz |
| freq | input | 11 | Frequency code |
| timed | input | 1 | 1 enables the length timeout |
| trig | input | 1 | Restart strobe, one cycle |
| tick64 | input | 1 | 64 Hz envelope strobe, one cycle |
| tick128 | input | 1 | 128 Hz sweep strobe, one cycle |
| tick256 | input | 1 | 256 Hz length strobe, one cycle |
| sample | output | 4 | Amplitude sample |
| active | output | 1 | Channel is playing |

## Verification
Five properties are checked on every cycle:
- The output is silent whenever the channel is inactive.
- A nonzero sample always equals the envelope level.
- The level and the phase each move by at most one step per cycle, so the level cannot wrap.
- A trigger always sets `active`.
- `active` only drops right after a sweep or length strobe.

The numeric rules are shown only by the bench's scenarios, which measure the length of each high run and the sampled level. These rules are the step length (2048 − F), the four duty widths, the results of F ± (F >> n), the sweep and envelope intervals, and the exact pulse on which the length timeout or the sweep overflow stops the voice.

// File: rtl/sqtone_pkg.sv
package sqtone_pkg;

    localparam int FREQ_W  = 11;
    localparam int PHASE_W = 5;
    localparam int VOL_W   = 4;
    localparam int RATE_W  = 3;
    localparam int LEN_W   = 6;

    typedef enum logic [1:0] {
        DUTY_EIGHTH  = 2'd0,
        DUTY_QUARTER = 2'd1,
        DUTY_HALF    = 2'd2,
        DUTY_THREEQ  = 2'd3
    } duty_e;

endpackage

// File: rtl/sqtone_wave.sv
module sqtone_wave
    import sqtone_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int PW = PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          trig,
    input  logic [FW-1:0] trig_freq,
    input  logic [FW-1:0] work_freq,
    input  logic [1:0]    duty,
    output logic          high,
    output logic [PW-1:0] phase
);
    localparam int CW    = FW + 1;
    localparam int STEPS = 1 << PW;
    localparam logic [CW-1:0] SPAN = CW'(1 << FW);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] ph;
    } wave_t;

    wave_t         st_q, st_d;
    logic [CW:0]   thr;
    logic [CW-1:0] period;

    always_comb begin
        st_d   = st_q;
        period = SPAN - {1'b0, work_freq};
        if (trig) begin
            st_d.cnt = SPAN - {1'b0, trig_freq};
            st_d.ph  = '0;
        end else if (run) begin
            if (st_q.cnt <= ONE) begin
                st_d.cnt = period;
                st_d.ph  = st_q.ph + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_comb begin
        case (duty_e'(duty))
            DUTY_EIGHTH:  thr = (CW+1)'(STEPS / 8);
            DUTY_QUARTER: thr = (CW+1)'(STEPS / 4);
            DUTY_HALF:    thr = (CW+1)'(STEPS / 2);
            default:      thr = (CW+1)'((3 * STEPS) / 4);
        endcase
    end

    assign high  = ((CW+1)'(st_q.ph) < thr);
    assign phase = st_q.ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sqtone_sweep.sv
module sqtone_sweep
    import sqtone_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          trig,
    input  logic          tick,
    input  logic [FW-1:0] field,
    input  logic [2:0]    shift,
    input  logic          sub,
    input  logic [RW-1:0] rate,
    output logic [FW-1:0] work_freq,
    output logic          ovf
);
    localparam logic [RW-1:0] ONE = RW'(1);

    typedef struct packed {
        logic [FW-1:0] work;
        logic [FW-1:0] seen;
        logic [RW-1:0] cnt;
    } sweep_t;

    sweep_t      st_q, st_d;
    logic [FW-1:0] delta;
    logic [FW:0]   sum;
    logic          fire;

    always_comb begin
        st_d  = st_q;
        delta = st_q.work >> shift;
        sum   = {1'b0, st_q.work} + {1'b0, delta};
        fire  = 1'b0;
        ovf   = 1'b0;
        if (trig) begin
            st_d.work = field;
            st_d.seen = field;
            st_d.cnt  = rate;
        end else begin
            if (run && tick && (rate != '0)) begin
                if (st_q.cnt <= ONE) begin
                    st_d.cnt = rate;
                    fire     = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            if (field != st_q.seen) begin
                st_d.work = field;
                st_d.seen = field;
            end else if (fire) begin
                if (sub) begin
                    if (delta <= st_q.work) st_d.work = st_q.work - delta;
                end else if (sum[FW]) begin
                    ovf = 1'b1;
                end else begin
                    st_d.work = sum[FW-1:0];
                end
            end
        end
    end

    assign work_freq = st_q.work;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sqtone_env.sv
module sqtone_env
    import sqtone_pkg::*;
#(
    parameter int VW = VOL_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          trig,
    input  logic          tick,
    input  logic [RW-1:0] step,
    input  logic          up,
    input  logic [VW-1:0] init,
    output logic [VW-1:0] vol
);
    localparam logic [RW-1:0] ONE  = RW'(1);
    localparam logic [VW-1:0] VMAX = '1;

    typedef struct packed {
        logic [VW-1:0] lvl;
        logic [RW-1:0] cnt;
    } env_t;

    env_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.lvl = init;
            st_d.cnt = step;
        end else if (run && tick && (step != '0)) begin
            if (st_q.cnt <= ONE) begin
                st_d.cnt = step;
                if (up) begin
                    if (st_q.lvl != VMAX) st_d.lvl = st_q.lvl + 1'b1;
                end else begin
                    if (st_q.lvl != '0) st_d.lvl = st_q.lvl - 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    assign vol = st_q.lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sqtone_len.sv
module sqtone_len
    import sqtone_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          trig,
    input  logic          tick,
    input  logic          timed,
    input  logic [LW-1:0] len_val,
    output logic          expire
);
    localparam int CW = LW + 1;
    localparam logic [CW-1:0] FULL = CW'(1 << LW);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } len_t;

    len_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (trig) begin
            st_d.cnt = FULL - {1'b0, len_val};
        end else if (run && timed && tick) begin
            if (st_q.cnt <= ONE) begin
                st_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sqtone_chan.sv
module sqtone_chan
    import sqtone_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          sweep_shift,
    input  logic                sweep_sub,
    input  logic [RATE_W-1:0]   sweep_time,
    input  logic [1:0]          duty,
    input  logic [RATE_W-1:0]   env_step,
    input  logic                env_up,
    input  logic [VOL_W-1:0]    env_init,
    input  logic [LEN_W-1:0]    len_val,
    input  logic [FREQ_W-1:0]   freq,
    input  logic                timed,
    input  logic                trig,
    input  logic                tick64,
    input  logic                tick128,
    input  logic                tick256,
    output logic [VOL_W-1:0]    sample,
    output logic                active
);
    typedef struct packed {
        logic on;
    } chan_t;

    chan_t st_q, st_d;

    logic [FREQ_W-1:0]  work_freq;
    logic [PHASE_W-1:0] phase_w;
    logic [VOL_W-1:0]   vol_w;
    logic               high_w;
    logic               ovf_w;
    logic               expire_w;

    sqtone_sweep #(.FW(FREQ_W), .RW(RATE_W)) sweep_i (
        .clk(clk), .rst_n(rst_n), .run(st_q.on), .trig(trig), .tick(tick128),
        .field(freq), .shift(sweep_shift), .sub(sweep_sub), .rate(sweep_time),
        .work_freq(work_freq), .ovf(ovf_w)
    );

    sqtone_wave #(.FW(FREQ_W), .PW(PHASE_W)) wave_i (
        .clk(clk), .rst_n(rst_n), .run(st_q.on), .trig(trig),
        .trig_freq(freq), .work_freq(work_freq), .duty(duty),
        .high(high_w), .phase(phase_w)
    );

    sqtone_env #(.VW(VOL_W), .RW(RATE_W)) env_i (
        .clk(clk), .rst_n(rst_n), .run(st_q.on), .trig(trig), .tick(tick64),
        .step(env_step), .up(env_up), .init(env_init), .vol(vol_w)
    );

    sqtone_len #(.LW(LEN_W)) len_i (
        .clk(clk), .rst_n(rst_n), .run(st_q.on), .trig(trig), .tick(tick256),
        .timed(timed), .len_val(len_val), .expire(expire_w)
    );

    always_comb begin
        st_d = st_q;
        if (trig)                     st_d.on = 1'b1;
        else if (ovf_w || expire_w)   st_d.on = 1'b0;
    end

    assign active = st_q.on;
    assign sample = (st_q.on && high_w) ? vol_w : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sqtone_chk.sv
module sqtone_chk #(
    parameter int VW = 4,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig,
    input logic          tick128,
    input logic          tick256,
    input logic          active,
    input logic [VW-1:0] sample,
    input logic [VW-1:0] vol,
    input logic [PW-1:0] phase
);
    logic [VW:0] vol_x;
    assign vol_x = {1'b0, vol};

    // R2
    trig_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> active);

    // R5
    silent_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (sample == '0));

    // R5
    sample_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample != '0) |-> (sample == vol));

    // R6
    env_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> ((vol_x <= $past(vol_x) + 1'b1) && ($past(vol_x) <= vol_x + 1'b1)));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> ((phase == $past(phase)) || (phase == $past(phase) + 1'b1)));

    // R9
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(tick128) || $past(tick256)));
endmodule

bind sqtone_chan sqtone_chk #(.VW(sqtone_pkg::VOL_W), .PW(sqtone_pkg::PHASE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .tick128(tick128), .tick256(tick256),
    .active(active), .sample(sample), .vol(vol_w), .phase(phase_w)
);

// File: tb/sqtone_chan_tb_top.sv
`timescale 1ns/1ps
module sqtone_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sweep_shift = '0;
    logic        sweep_sub = 1'b1;
    logic [2:0]  sweep_time = '0;
    logic [1:0]  duty = 2'd2;
    logic [2:0]  env_step = '0;
    logic        env_up = 1'b0;
    logic [3:0]  env_init = 4'd15;
    logic [5:0]  len_val = '0;
    logic [10:0] freq = 11'd2047;
    logic        timed = 1'b0;
    logic        trig = 1'b0;
    logic        tick64 = 1'b0;
    logic        tick128 = 1'b0;
    logic        tick256 = 1'b0;
    logic [3:0]  sample;
    logic        active;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    sqtone_chan dut_i (
        .clk(clk), .rst_n(rst_n), .sweep_shift(sweep_shift), .sweep_sub(sweep_sub),
        .sweep_time(sweep_time), .duty(duty), .env_step(env_step), .env_up(env_up),
        .env_init(env_init), .len_val(len_val), .freq(freq), .timed(timed),
        .trig(trig), .tick64(tick64), .tick128(tick128), .tick256(tick256),
        .sample(sample), .active(active)
    );

    // each entry: freq(11) duty(2) level(4)
    localparam logic [16:0] VECS [0:5] = '{
        {11'd2047, 2'd0, 4'd15},
        {11'd2047, 2'd1, 4'd9},
        {11'd2046, 2'd2, 4'd3},
        {11'd2044, 2'd3, 4'd12},
        {11'd2040, 2'd2, 4'd7},
        {11'd2032, 2'd1, 4'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic pulse(input int which, input int n);
        repeat (n) begin
            @(negedge clk);
            case (which)
                64:      tick64 = 1'b1;
                128:     tick128 = 1'b1;
                default: tick256 = 1'b1;
            endcase
            @(negedge clk);
            tick64 = 1'b0; tick128 = 1'b0; tick256 = 1'b0;
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (sample != 0 && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic next_high(output int n);
        int g;
        g = 0;
        while (sample != 0 && g < 70000) begin g++; @(negedge clk); end
        g = 0;
        while (sample == 0 && g < 70000) begin g++; @(negedge clk); end
        count_high(n);
    endtask

    task automatic read_vol(output int v);
        v = 0;
        for (int i = 0; i < 40; i++) begin
            if (sample != 0) begin
                v = sample;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int n, v, thr;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(active == 1'b0, "R1 active", active, 0);
        chk(sample == 4'd0, "R1 sample", sample, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(active == 1'b0, "R1 idle after reset", active, 0);

        // R3 R4 R5 table walk: high run length and level after trigger
        for (int i = 0; i < 6; i++) begin
            freq     = VECS[i][16:6];
            duty     = VECS[i][5:4];
            env_init = VECS[i][3:0];
            do_trig();
            chk(active == 1'b1, "R2 active after trigger", active, 1);
            chk(sample == VECS[i][3:0], "R5 level while high", sample, VECS[i][3:0]);
            case (VECS[i][5:4])
                2'd0: thr = 4;
                2'd1: thr = 8;
                2'd2: thr = 16;
                default: thr = 24;
            endcase
            count_high(n);
            chk(n == thr * (2048 - VECS[i][16:6]), "R3 R4 high run", n,
                thr * (2048 - VECS[i][16:6]));
        end

        // R11 frequency change without trigger
        duty = 2'd2; freq = 11'd2040; env_init = 4'd8; sweep_time = 3'd0;
        do_trig();
        freq = 11'd2044;
        next_high(n);
        chk(n == 64, "R11 new period without trigger", n, 64);

        // R7 sweep every 3 pulses, R8 subtraction result
        freq = 11'd2040; sweep_shift = 3'd7; sweep_sub = 1'b1; sweep_time = 3'd3;
        do_trig();
        pulse(128, 2);
        next_high(n);
        chk(n == 128, "R7 no sweep before k pulses", n, 128);
        pulse(128, 1);
        next_high(n);
        chk(n == 368, "R8 subtract sweep 2040->2025", n, 368);

        // R7 sweep time 0 disables
        sweep_time = 3'd0;
        do_trig();
        pulse(128, 3);
        next_high(n);
        chk(n == 128, "R7 sweep off", n, 128);

        // R8 addition without overflow: 1800 + 14 = 1814
        freq = 11'd1800; sweep_sub = 1'b0; sweep_time = 3'd1;
        do_trig();
        pulse(128, 1);
        next_high(n);
        chk(n == 16 * 234, "R8 add sweep 1800->1814", n, 16 * 234);

        // R9 addition overflow stops the channel: 2040 + 15 >= 2048
        freq = 11'd2040;
        do_trig();
        pulse(128, 1);
        chk(active == 1'b0, "R9 overflow clears active", active, 0);
        chk(sample == 4'd0, "R9 silent after overflow", sample, 0);
        sweep_time = 3'd0;

        // R6 envelope
        freq = 11'd2047; duty = 2'd3;
        env_init = 4'd5; env_up = 1'b1; env_step = 3'd2;
        do_trig();
        pulse(64, 1);
        read_vol(v);
        chk(v == 5, "R6 no step before E pulses", v, 5);
        pulse(64, 1);
        read_vol(v);
        chk(v == 6, "R6 step up", v, 6);
        env_init = 4'd14; env_step = 3'd1;
        do_trig();
        pulse(64, 3);
        read_vol(v);
        chk(v == 15, "R6 saturate at 15", v, 15);
        env_init = 4'd2; env_up = 1'b0;
        do_trig();
        pulse(64, 4);
        read_vol(v);
        chk(v == 0, "R6 saturate at 0", v, 0);
        chk(active == 1'b1, "R6 mute keeps active", active, 1);
        env_init = 4'd7; env_step = 3'd0;
        do_trig();
        pulse(64, 3);
        read_vol(v);
        chk(v == 7, "R6 step 0 freezes", v, 7);

        // R10 length timeout
        timed = 1'b1; len_val = 6'd62;
        do_trig();
        pulse(256, 1);
        chk(active == 1'b1, "R10 still active after 1 of 2", active, 1);
        pulse(256, 1);
        chk(active == 1'b0, "R10 stops after 64-L pulses", active, 0);
        chk(sample == 4'd0, "R10 silent when stopped", sample, 0);
        do_trig();
        chk(active == 1'b1, "R2 trigger restarts stopped channel", active, 1);
        timed = 1'b0; len_val = 6'd63;
        do_trig();
        pulse(256, 3);
        chk(active == 1'b1, "R10 untimed ignores length", active, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule